// File: doc/BRIEF.md
# Segmented stack push/pop unit

This block keeps a 16-bit stack offset and moves 16-bit words between a requester and a byte-wide synchronous memory. The memory address is formed by shifting a 16-bit stack segment value left by four bits and adding the offset, which gives a 20-bit physical address. A word always occupies two neighbouring bytes. The low byte sits at the lower address.

Requests arrive on a valid/ready channel. `req_ready` is high exactly when the unit is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the requester must hold its request, and `req_valid` has no effect. A push lowers the offset by two at the moment it is accepted. It then writes the low byte and the high byte in two consecutive cycles at the new address. A pop reads the two bytes at the current address. It returns the word on a one-cycle `rsp_valid` strobe and only then raises the offset by two. The response has no back-pressure: the requester must take it in the strobe cycle. `stack_seg` must stay stable while `busy` is high.

Top module: `seg_stack_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the offset returns to 0, and in the next cycle `busy`, `mem_en`, `mem_we` and `rsp_valid` are 0.
- R2: On the edge that accepts a push (`req_op`=0), `sp_out` drops by 2 before any byte is written. The first write cycle already shows the new value.
- R3: A push drives two write cycles right after acceptance, each with `mem_en`=1 and `mem_we`=1. The first has address segment*16+offset and data bits 7:0. The second has that address plus 1 and data bits 15:8.
- R4: The physical address sum, including the +1 for the high byte, wraps modulo 2^20.
- R5: A pop (`req_op`=1) drives two read cycles right after acceptance, with `mem_we`=0: first at segment*16+offset, then at that address plus 1. The offset does not change until the edge that ends the response cycle, where it rises by 2.
- R6: The third busy cycle of a pop has `rsp_valid`=1 and `rsp_data` = {byte at address+1, byte at address}. `rsp_valid` is 0 in every other cycle.
- R7: `busy` is high for exactly 2 cycles per push and 3 cycles per pop, and `req_ready` equals not `busy`. Requests presented while busy are not accepted and do not change the offset or the memory.
- R8: Offset arithmetic wraps modulo 2^16: a push at offset 0 yields 0xFFFE, and a pop at 0xFFFE yields 0.
- R9: When the unit is idle, `mem_en` and `mem_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (idle) |
| req_op | input | 1 | 0 = push, 1 = pop |
| req_data | input | 16 | Word to push |
| stack_seg | input | 16 | Stack segment value |
| busy | output | 1 | Operation in progress |
| sp_out | output | 16 | Current stack offset |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, one cycle after the read address |
| rsp_valid | output | 1 | Popped word strobe |
| rsp_data | output | 16 | Popped word |

## Verification
The bench builds the unit with its default widths: a 16-bit offset and a four-bit segment shift. With these widths, one push from reset already wraps the offset to 0xFFFE. A segment of 0xF001 pushes the physical sum past 2^20, so both offset and address wrap are reached within a few operations. Long stretches of random pushes and pops, with requests held through busy periods, check that every byte written is read back in LIFO order.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WLO,
    ST_WHI,
    ST_RLO,
    ST_RHI,
    ST_RFIN
  } ss_state_e;

  localparam logic OP_PUSH = 1'b0;
  localparam logic OP_POP  = 1'b1;
endpackage

// File: rtl/ss_ptr.sv
module ss_ptr #(
  parameter int OFS_W = 16,
  parameter int STEP  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dec,
  input  logic             inc,
  output logic [OFS_W-1:0] sp
);
  localparam logic [OFS_W-1:0] STEP_V = OFS_W'(STEP);

  always_ff @(posedge clk) begin
    if (rst)      sp <= '0;
    else if (dec) sp <= sp - STEP_V;
    else if (inc) sp <= sp + STEP_V;
  end

  // R2 R8: decrement by two, modulo 2^OFS_W
  a_r2_push_dec: assert property (@(posedge clk) disable iff (rst)
    dec |=> sp == $past(sp) - STEP_V);
  // R5 R8: increment by two after the response
  a_r5_pop_inc: assert property (@(posedge clk) disable iff (rst)
    (inc && !dec) |=> sp == $past(sp) + STEP_V);
  // R7: no movement without an update request
  a_r7_sp_hold: assert property (@(posedge clk) disable iff (rst)
    (!dec && !inc) |=> $stable(sp));
endmodule

// File: rtl/ss_addr.sv
module ss_addr #(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PA_W     = OFS_W + SEG_SHIFT
) (
  input  logic [OFS_W-1:0] seg,
  input  logic [OFS_W-1:0] ofs,
  input  logic             byte_hi,
  output logic [PA_W-1:0]  addr
);
  logic [PA_W-1:0] seg_base;

  always_comb begin
    seg_base = {seg, {SEG_SHIFT{1'b0}}};
    addr     = seg_base + PA_W'(ofs) + PA_W'(byte_hi);
  end
endmodule

// File: rtl/ss_ctrl.sv
module ss_ctrl
  import ss_pkg::*;
#(
  parameter int BYTE_W  = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_op,
  input  logic [WORD_W-1:0] req_data,
  output logic              req_ready,
  output logic              busy,
  output logic              sp_dec,
  output logic              sp_inc,
  output logic              byte_hi,
  output logic              mem_en,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data
);
  ss_state_e         state, state_n;
  logic [WORD_W-1:0] data_q;
  logic [BYTE_W-1:0] lo_q;
  logic              accept;

  always_comb begin
    busy      = (state != ST_IDLE);
    req_ready = !busy;
    accept    = req_valid && req_ready;
    sp_dec    = accept && (req_op == OP_PUSH);
    sp_inc    = (state == ST_RFIN);
    byte_hi   = (state == ST_WHI) || (state == ST_RHI);
    mem_we    = (state == ST_WLO) || (state == ST_WHI);
    mem_en    = mem_we || (state == ST_RLO) || (state == ST_RHI);
    mem_wdata = byte_hi ? data_q[WORD_W-1:BYTE_W] : data_q[BYTE_W-1:0];
    rsp_valid = (state == ST_RFIN);
    rsp_data  = {mem_rdata, lo_q};
    unique case (state)
      ST_IDLE: state_n = accept ? ((req_op == OP_PUSH) ? ST_WLO : ST_RLO) : ST_IDLE;
      ST_WLO:  state_n = ST_WHI;
      ST_RLO:  state_n = ST_RHI;
      ST_RHI:  state_n = ST_RFIN;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      data_q <= '0;
      lo_q   <= '0;
    end else begin
      state <= state_n;
      if (accept)            data_q <= req_data;
      if (state == ST_RHI)   lo_q   <= mem_rdata;
    end
  end

  // R3: writes only as part of an enabled access
  a_r3_we_needs_en: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en);
  // R3: low-byte write is followed by the high-byte write
  a_r3_hi_after_lo: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !byte_hi) |=> (mem_we && byte_hi));
  // R5: low-byte read is followed by the high-byte read
  a_r5_read_order: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_we && !byte_hi) |=> (mem_en && !mem_we && byte_hi));
  // R6: response strobe lasts one cycle
  a_r6_rsp_single: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R9: idle means no memory access
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_en);
  // R7: an accepted request makes the unit busy
  a_r7_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> busy);
endmodule

// File: rtl/seg_stack_unit.sv
module seg_stack_unit #(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int BYTE_W    = 8,
  localparam int PA_W     = OFS_W + SEG_SHIFT,
  localparam int WORD_W   = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [WORD_W-1:0] req_data,
  input  logic [OFS_W-1:0]  stack_seg,
  output logic              busy,
  output logic [OFS_W-1:0]  sp_out,
  output logic              mem_en,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data
);
  logic sp_dec, sp_inc, byte_hi;

  ss_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_op(req_op), .req_data(req_data),
    .req_ready(req_ready), .busy(busy),
    .sp_dec(sp_dec), .sp_inc(sp_inc), .byte_hi(byte_hi),
    .mem_en(mem_en), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  ss_ptr #(.OFS_W(OFS_W), .STEP(WORD_W / BYTE_W)) u_ptr (
    .clk(clk), .rst(rst), .dec(sp_dec), .inc(sp_inc), .sp(sp_out)
  );

  ss_addr #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_addr (
    .seg(stack_seg), .ofs(sp_out), .byte_hi(byte_hi), .addr(mem_addr)
  );

  // R2: the offset seen by the first push write is already lowered
  a_r2_dec_before_write: assert property (@(posedge clk) disable iff (rst)
    sp_dec |=> (mem_we && sp_out == $past(sp_out) - OFS_W'(2)));
  // R5: the offset is unchanged across the pop read cycles
  a_r5_sp_held_on_read: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_we) |=> $stable(sp_out));
endmodule

// File: tb/sim_seg_stack_unit.sv
`timescale 1ns/100ps
module sim_seg_stack_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_op = 1'b0;
  logic [15:0] req_data = '0;
  logic [15:0] stack_seg = 16'h1000;
  logic        req_ready, busy, mem_en, mem_we, rsp_valid;
  logic [15:0] sp_out, rsp_data;
  logic [19:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  int vectors = 0;
  int fails   = 0;
  bit started = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  seg_stack_unit u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_data(req_data), .stack_seg(stack_seg),
    .busy(busy), .sp_out(sp_out), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  // byte RAM seen by the design: synchronous read, one cycle latency
  logic [7:0] ram [int];
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[int'(mem_addr)] = mem_wdata;
      else mem_rdata <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
    end
  end

  // reference model: phase 0 idle, 1-2 push writes, 3-5 pop
  int m_sp = 0;
  int m_ph = 0;
  int m_data = 0;
  logic [7:0] mref [int];

  function automatic int m_addr(int ph);
    int hi;
    hi = (ph == 2 || ph == 4) ? 1 : 0;
    return (int'(stack_seg) * 16 + m_sp + hi) & 32'hFFFFF;
  endfunction

  function automatic logic [7:0] mget(int a);
    return mref.exists(a) ? mref[a] : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sp = 0; m_ph = 0;
    end else begin
      case (m_ph)
        0: if (req_valid) begin
             m_data = int'(req_data);
             if (req_op == 1'b0) begin m_sp = (m_sp - 2) & 16'hFFFF; m_ph = 1; end
             else m_ph = 3;
           end
        1: begin mref[m_addr(1)] = m_data[7:0];  m_ph = 2; end
        2: begin mref[m_addr(2)] = m_data[15:8]; m_ph = 0; end
        3: m_ph = 4;
        4: m_ph = 5;
        default: begin m_sp = (m_sp + 2) & 16'hFFFF; m_ph = 0; end
      endcase
    end
    started = 1;
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      if (rst) chk("R1 busy after reset", int'(busy), 0);
      chk("R7 busy", int'(busy), int'(m_ph != 0));
      chk("R7 req_ready", int'(req_ready), int'(m_ph == 0));
      chk("R2 R5 R8 sp_out", int'(sp_out), m_sp);
      chk("R9 R1 mem_en", int'(mem_en), int'(m_ph >= 1 && m_ph <= 4));
      chk("R3 R9 mem_we", int'(mem_we), int'(m_ph == 1 || m_ph == 2));
      if (m_ph >= 1 && m_ph <= 4) chk("R3 R4 R5 mem_addr", int'(mem_addr), m_addr(m_ph));
      if (m_ph == 1) chk("R3 low byte", int'(mem_wdata), m_data & 8'hFF);
      if (m_ph == 2) chk("R3 high byte", int'(mem_wdata), (m_data >> 8) & 8'hFF);
      chk("R6 rsp_valid", int'(rsp_valid), int'(m_ph == 5));
      if (m_ph == 5)
        chk("R6 rsp_data", int'(rsp_data),
            {16'h0, mget((int'(stack_seg) * 16 + m_sp + 1) & 32'hFFFFF),
                    mget((int'(stack_seg) * 16 + m_sp) & 32'hFFFFF)});
    end
  end

  task automatic cyc(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic op(logic o, logic [15:0] d);
    req_valid = 1'b1; req_op = o; req_data = d;
    do cyc(1); while (m_ph == 0 && !(o == 1'b0 && sp_out != sp_out));
    req_valid = 1'b0;
    while (busy) cyc(1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R8: push at offset 0 wraps to 0xFFFE; R2 R3 directed
    op(1'b0, 16'h1234);
    op(1'b0, 16'hABCD);
    // R5 R6: LIFO pops, R8 wrap back to 0
    op(1'b1, 16'h0);
    op(1'b1, 16'h0);
    // R4: segment pushes the physical sum past 2^20
    stack_seg = 16'hF001;
    op(1'b0, 16'h5AA5);
    op(1'b0, 16'h0FF0);
    op(1'b1, 16'h0);
    op(1'b1, 16'h0);
    // R7: request held high across busy periods, back to back
    req_valid = 1'b1; req_op = 1'b0; req_data = 16'hBEEF;
    cyc(9);
    req_op = 1'b1;
    cyc(12);
    req_valid = 1'b0;
    while (busy) cyc(1);
    // random traffic over several segments
    for (int blk = 0; blk < 4; blk++) begin
      stack_seg = 16'($urandom);
      for (int i = 0; i < 1500; i++) begin
        req_valid = 1'($urandom);
        req_op    = 1'($urandom);
        req_data  = 16'($urandom);
        cyc(1);
      end
      req_valid = 1'b0;
      while (busy) cyc(1);
      cyc(1);
    end
    // R1: reset mid-operation returns offset to 0
    req_valid = 1'b1; req_op = 1'b0;
    cyc(1);
    rst = 1'b1; req_valid = 1'b0;
    cyc(2);
    chk("R1 sp_out", int'(sp_out), 0);
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    rst = 1'b0;
    cyc(3);
    finish_run();
  end
endmodule